// File: doc/BRIEF.md
# Binary Sobel Edge Merge Unit

This block sits at the end of a motion-detection chain. It receives three neighbouring rows of a binarized frame, packed one pixel per bit into 32-pixel words, together with the 8-bit grayscale pixels of the middle row, one per cycle. For every middle-row pixel it evaluates the horizontal and vertical Sobel responses on the binary neighbourhood. If both responses are zero, the grayscale pixel passes through unchanged. If either response is nonzero, the pixel is an edge and is forced to zero. The result is one merged grayscale pixel per input pixel, after a fixed delay.

A row is presented as an unbroken burst of valid cycles, framed by start-of-row and end-of-row markers. The packed row words are sampled only on the first pixel of each 32-pixel group. The block aligns the grayscale pixel with its own edge decision. It also clears every neighbour that lies outside the image: to the left of the first column, to the right of the last column, above the first row and below the last row.

Top module: `sobel_edge_merge`

## Requirements
- R1: During reset and on the first cycle after it, `out_vld` is 0 and `out_pix` is 0.
- R2: Each valid input pixel produces exactly one valid output two clock edges after it is sampled, in input order. Whenever `out_vld` is 0, `out_pix` is 0. Within a row, `in_vld` stays high from the start-of-row cycle through the end-of-row cycle.
- R3: When both Sobel responses of a pixel are zero, the output equals the input grayscale pixel in every one of its 8 bits.
- R4: The responses use a horizontal kernel with left column weights (1,2,1) and right column weights (-1,-2,-1), and a vertical kernel with top row weights (-1,-2,-1) and bottom row weights (1,2,1). Each response lies in [-4,+4]. If either response is nonzero, the output is 0.
- R5: Pixel i of a 32-pixel group is bit i of the row word (LSB is the leftmost pixel). Groups count from the start-of-row pixel. Row words are sampled only on the first pixel of a group, and their values on all other cycles have no effect on the output.
- R6: The neighbour to the left of a start-of-row pixel and the neighbour to the right of an end-of-row pixel are treated as 0. This holds when rows follow back to back with no idle cycle.
- R7: When `in_first_row` is high at start-of-row, the top row word is treated as all zeros for the whole row. When `in_last_row` is high at start-of-row, the bottom row word is treated as all zeros for the whole row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input pixel valid |
| in_sol | input | 1 | First pixel of a row |
| in_eol | input | 1 | Last pixel of a row |
| in_first_row | input | 1 | Row is the top image row (sampled at start-of-row) |
| in_last_row | input | 1 | Row is the bottom image row (sampled at start-of-row) |
| in_top_word | input | 32 | Packed binary pixels of the row above |
| in_mid_word | input | 32 | Packed binary pixels of the current row |
| in_bot_word | input | 32 | Packed binary pixels of the row below |
| in_pix | input | 8 | Grayscale pixel of the current row |
| out_vld | output | 1 | Merged pixel valid |
| out_pix | output | 8 | Merged grayscale pixel |

## Verification
The bench covers several cases where a wrong design would show:
- Row widths that are not a multiple of 32, with rows back to back. A design that leaks the next row's first column into the last pixel of a row, or keeps a stale left neighbour, marks false edges at the borders.
- Random data on the row words on every cycle that does not start a group, and random words above the first row and below the last row. A design that samples too often, or skips the top and bottom masking, corrupts the edge decision.
- Flat all-zero and all-one images. A design whose merge uses the wrong polarity, or whose pixel delay is off by one cycle, would zero the whole image or emit shifted pixels.

// File: rtl/sobel_edge_merge_pkg.sv
// Package: shared types for the binary Sobel edge merge unit.
// Assumes: one binary pixel per bit; a column holds the three row bits of
// one image column (top, middle, bottom).
package sobel_edge_merge_pkg;

    // Three vertically adjacent binary pixels of one image column.
    typedef struct packed {
        logic t;
        logic m;
        logic b;
    } col_t;

    localparam int unsigned RESP_W = 4;   // signed Sobel response width

    // Weighted column sum t + 2m + b, range 0..4.
    function automatic logic [2:0] col_weight(input col_t c);
        return {2'b00, c.t} + {1'b0, c.m, 1'b0} + {2'b00, c.b};
    endfunction

    // Weighted row sum across three columns, range 0..4.
    function automatic logic [2:0] row_weight(input logic l, input logic m,
                                              input logic r);
        return {2'b00, l} + {1'b0, m, 1'b0} + {2'b00, r};
    endfunction

endpackage

// File: rtl/sem_col_unpack.sv
// Module: sem_col_unpack
// Turns the packed row words into one three-bit column per valid pixel.
// Assumes: WORD_W is a power of two and at least 2. Words are sampled on
// the start-of-row pixel and on every WORD_W-th pixel after it. Row flags
// are sampled at start-of-row and mask the top or bottom row for the row.
module sem_col_unpack
    import sobel_edge_merge_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_sol,
    input  logic              in_first_row,
    input  logic              in_last_row,
    input  logic [WORD_W-1:0] in_top_word,
    input  logic [WORD_W-1:0] in_mid_word,
    input  logic [WORD_W-1:0] in_bot_word,
    output col_t              col_now
);
    localparam int unsigned IDX_W = $clog2(WORD_W);

    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] sh_top_q, sh_mid_q, sh_bot_q;
    logic              first_q, last_q;
    logic              load;
    logic              first_eff, last_eff;
    col_t              raw;

    // Sample the row words on the first pixel of each group.
    assign load      = in_vld && (in_sol || (idx_q == '0));
    // Row flags take effect in the same cycle as start-of-row.
    assign first_eff = in_sol ? in_first_row : first_q;
    assign last_eff  = in_sol ? in_last_row  : last_q;

    // Pixel index within the group, remaining word bits and row flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            sh_top_q <= '0;
            sh_mid_q <= '0;
            sh_bot_q <= '0;
            first_q  <= 1'b0;
            last_q   <= 1'b0;
        end else if (in_vld) begin
            idx_q <= in_sol ? IDX_W'(1) : idx_q + IDX_W'(1);
            if (load) begin
                sh_top_q <= in_top_word >> 1;
                sh_mid_q <= in_mid_word >> 1;
                sh_bot_q <= in_bot_word >> 1;
            end else begin
                sh_top_q <= sh_top_q >> 1;
                sh_mid_q <= sh_mid_q >> 1;
                sh_bot_q <= sh_bot_q >> 1;
            end
            if (in_sol) begin
                first_q <= in_first_row;
                last_q  <= in_last_row;
            end
        end
    end

    // Select the current column from the live words or the shifted copy.
    always_comb begin
        if (load) begin
            raw.t = in_top_word[0];
            raw.m = in_mid_word[0];
            raw.b = in_bot_word[0];
        end else begin
            raw.t = sh_top_q[0];
            raw.m = sh_mid_q[0];
            raw.b = sh_bot_q[0];
        end
        col_now.t = raw.t & ~first_eff;
        col_now.m = raw.m;
        col_now.b = raw.b & ~last_eff;
    end

endmodule

// File: rtl/sem_window.sv
// Module: sem_window
// Holds the left and centre columns and the grayscale pixel of the pixel
// under evaluation. It presents the right column from the next cycle's
// live column, or zero after an end-of-row pixel.
// Assumes: in_vld is unbroken from start-of-row to end-of-row.
module sem_window
    import sobel_edge_merge_pkg::*;
#(
    parameter int unsigned PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_sol,
    input  logic             in_eol,
    input  logic [PIX_W-1:0] in_pix,
    input  col_t             col_now,
    output logic             win_vld,
    output col_t             win_left,
    output col_t             win_mid,
    output col_t             win_right,
    output logic [PIX_W-1:0] win_pix
);
    logic win_eol;

    // Advance the window on each valid pixel; a row start clears the left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_vld  <= 1'b0;
            win_left <= '0;
            win_mid  <= '0;
            win_pix  <= '0;
            win_eol  <= 1'b0;
        end else begin
            win_vld <= in_vld;
            if (in_vld) begin
                win_left <= in_sol ? col_t'('0) : win_mid;
                win_mid  <= col_now;
                win_pix  <= in_pix;
                win_eol  <= in_eol;
            end
        end
    end

    // The right neighbour is the column arriving now, unless the row ended.
    assign win_right = win_eol ? col_t'('0) : col_now;

endmodule

// File: rtl/sem_sobel.sv
// Module: sem_sobel
// Evaluates both Sobel responses on a 3x3 binary window and reports
// whether the pixel is free of gradient (keep = 1) or an edge (keep = 0).
// EDGE_IMPL selects the zero test: 0 = NOR over the two 4-bit responses,
// 1 = sum of magnitudes compared with zero. Both give the same result.
module sem_sobel
    import sobel_edge_merge_pkg::*;
#(
    parameter int unsigned EDGE_IMPL = 0
) (
    input  col_t left,
    input  col_t mid,
    input  col_t right,
    output logic keep
);
    logic signed [RESP_W-1:0] resp_h, resp_v;
    logic [2:0]               w_left, w_right, w_top, w_bot;

    // Weighted sums of the outer columns and outer rows.
    always_comb begin
        w_left  = col_weight(left);
        w_right = col_weight(right);
        w_top   = row_weight(left.t, mid.t, right.t);
        w_bot   = row_weight(left.b, mid.b, right.b);
        resp_h  = $signed({1'b0, w_left}) - $signed({1'b0, w_right});
        resp_v  = $signed({1'b0, w_bot})  - $signed({1'b0, w_top});
    end

    generate
        if (EDGE_IMPL == 0) begin : g_nor
            // No gradient exactly when every response bit is zero.
            assign keep = ~(|{resp_h, resp_v});
        end else begin : g_mag
            logic [RESP_W-1:0] mag_h, mag_v;
            logic [RESP_W:0]   mag_sum;
            // Sum of absolute responses; a nonzero sum marks an edge.
            always_comb begin
                mag_h   = resp_h[RESP_W-1] ? RESP_W'(-resp_h) : RESP_W'(resp_h);
                mag_v   = resp_v[RESP_W-1] ? RESP_W'(-resp_v) : RESP_W'(resp_v);
                mag_sum = {1'b0, mag_h} + {1'b0, mag_v};
            end
            assign keep = (mag_sum == '0);
        end
    endgenerate

endmodule

// File: rtl/sem_merge.sv
// Module: sem_merge
// Registers the merged pixel: the grayscale pixel ANDed with the keep bit
// copied across every pixel bit. Idle cycles drive zero.
module sem_merge #(
    parameter int unsigned PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_vld,
    input  logic [PIX_W-1:0] win_pix,
    input  logic             keep,
    output logic             out_vld,
    output logic [PIX_W-1:0] out_pix
);
    // Output register for the merged pixel and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_pix <= '0;
        end else begin
            out_vld <= win_vld;
            out_pix <= win_vld ? (win_pix & {PIX_W{keep}}) : '0;
        end
    end

endmodule

// File: rtl/sobel_edge_merge.sv
// Module: sobel_edge_merge (top)
// Binary Sobel edge detection merged into a grayscale pixel stream.
// Two-stage pipeline: the column window, then the Sobel test and merge.
// Assumes: rows arrive as unbroken valid bursts framed by in_sol/in_eol.
module sobel_edge_merge
    import sobel_edge_merge_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned PIX_W     = 8,
    parameter int unsigned EDGE_IMPL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_sol,
    input  logic              in_eol,
    input  logic              in_first_row,
    input  logic              in_last_row,
    input  logic [WORD_W-1:0] in_top_word,
    input  logic [WORD_W-1:0] in_mid_word,
    input  logic [WORD_W-1:0] in_bot_word,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              out_vld,
    output logic [PIX_W-1:0]  out_pix
);
    col_t             col_now;
    col_t             win_left, win_mid, win_right;
    logic             win_vld;
    logic [PIX_W-1:0] win_pix;
    logic             keep;

    sem_col_unpack #(.WORD_W(WORD_W)) u_unpack (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_vld       (in_vld),
        .in_sol       (in_sol),
        .in_first_row (in_first_row),
        .in_last_row  (in_last_row),
        .in_top_word  (in_top_word),
        .in_mid_word  (in_mid_word),
        .in_bot_word  (in_bot_word),
        .col_now      (col_now)
    );

    sem_window #(.PIX_W(PIX_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .in_sol    (in_sol),
        .in_eol    (in_eol),
        .in_pix    (in_pix),
        .col_now   (col_now),
        .win_vld   (win_vld),
        .win_left  (win_left),
        .win_mid   (win_mid),
        .win_right (win_right),
        .win_pix   (win_pix)
    );

    sem_sobel #(.EDGE_IMPL(EDGE_IMPL)) u_sobel (
        .left  (win_left),
        .mid   (win_mid),
        .right (win_right),
        .keep  (keep)
    );

    sem_merge #(.PIX_W(PIX_W)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_vld (win_vld),
        .win_pix (win_pix),
        .keep    (keep),
        .out_vld (out_vld),
        .out_pix (out_pix)
    );

endmodule

// File: rtl/sobel_edge_merge_chk.sv
// Module: sobel_edge_merge_chk
// Port-level checks on timing, idle value, merge mask and row framing.
// It is bound into every instance of the top module.
module sobel_edge_merge_chk #(
    parameter int unsigned PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic             in_eol,
    input logic [PIX_W-1:0] in_pix,
    input logic             out_vld,
    input logic [PIX_W-1:0] out_pix
);
    // R1: the first cycle out of reset shows no valid output.
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_vld);

    // R2: every valid input yields a valid output two edges later.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> ##2 out_vld);

    // R2: no input means no output two edges later.
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |-> ##2 !out_vld);

    // R2: the output is zero on idle cycles.
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_pix == '0));

    // R2: a row burst has no gap before its end-of-row pixel.
    p_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !in_eol) |=> in_vld);

    // R3/R4: the output is either the delayed pixel or all zeros.
    p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((out_pix == '0) || (out_pix == $past(in_pix, 2))));

endmodule

bind sobel_edge_merge sobel_edge_merge_chk #(.PIX_W(PIX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_eol  (in_eol),
    .in_pix  (in_pix),
    .out_vld (out_vld),
    .out_pix (out_pix)
);

// File: tb/sobel_edge_merge_tb.sv
module sobel_edge_merge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 32;
    localparam int PIX_W      = 8;
    localparam int MAXW       = 100;
    localparam int MAXH       = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
    logic              in_first_row = 1'b0, in_last_row = 1'b0;
    logic [WORD_W-1:0] in_top_word = '0, in_mid_word = '0, in_bot_word = '0;
    logic [PIX_W-1:0]  in_pix = '0;
    logic              out_vld;
    logic [PIX_W-1:0]  out_pix;

    sobel_edge_merge u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sol(in_sol),
        .in_eol(in_eol), .in_first_row(in_first_row), .in_last_row(in_last_row),
        .in_top_word(in_top_word), .in_mid_word(in_mid_word),
        .in_bot_word(in_bot_word), .in_pix(in_pix),
        .out_vld(out_vld), .out_pix(out_pix)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    bit    img [MAXH][MAXW];
    int    iw, ih;
    int    exp_q[$];
    int    tim_q[$];
    string tag_q[$];
    int    total = 0, bad = 0;
    bit    done = 0;
    bit    mon_on = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic int pb(input int x, input int y);
        if (x < 0 || y < 0 || x >= iw || y >= ih) return 0;
        return int'(img[y][x]);
    endfunction

    // Reference Sobel on the binary image with zero outside the frame.
    function automatic bit ref_edge(input int x, input int y);
        int eh, ev;
        eh = (pb(x-1,y-1) + 2*pb(x-1,y) + pb(x-1,y+1))
           - (pb(x+1,y-1) + 2*pb(x+1,y) + pb(x+1,y+1));
        ev = (pb(x-1,y+1) + 2*pb(x,y+1) + pb(x+1,y+1))
           - (pb(x-1,y-1) + 2*pb(x,y-1) + pb(x+1,y-1));
        return (eh != 0) || (ev != 0);
    endfunction

    // Packed word k of row y; bits past the row end and rows outside are random.
    function automatic logic [WORD_W-1:0] row_word(input int y, input int k);
        logic [WORD_W-1:0] w;
        w = $urandom;
        if (y >= 0 && y < ih)
            for (int i = 0; i < WORD_W; i++)
                if (k*WORD_W + i < iw) w[i] = img[y][k*WORD_W + i];
        return w;
    endfunction

    // 0 random, 1 zeros, 2 ones, 3 single dot, 4 vertical stripe.
    task automatic fill(input int mode, input int w, input int h);
        iw = w; ih = h;
        for (int y = 0; y < h; y++)
            for (int x = 0; x < w; x++)
                case (mode)
                    0: img[y][x] = bit'($urandom % 2);
                    1: img[y][x] = 1'b0;
                    2: img[y][x] = 1'b1;
                    3: img[y][x] = (x == w/2) && (y == h/2);
                    default: img[y][x] = (x == w/2);
                endcase
    endtask

    task automatic run_image(input string tag, input int gapmax);
        for (int y = 0; y < ih; y++) begin
            for (int x = 0; x < iw; x++) begin
                @(negedge clk);
                in_vld       = 1'b1;
                in_sol       = (x == 0);
                in_eol       = (x == iw - 1);
                in_first_row = (x == 0) ? (y == 0)      : bit'($urandom % 2);
                in_last_row  = (x == 0) ? (y == ih - 1) : bit'($urandom % 2);
                if (x % WORD_W == 0) begin
                    in_top_word = row_word(y - 1, x / WORD_W);
                    in_mid_word = row_word(y,     x / WORD_W);
                    in_bot_word = row_word(y + 1, x / WORD_W);
                end else begin
                    in_top_word = $urandom;
                    in_mid_word = $urandom;
                    in_bot_word = $urandom;
                end
                in_pix = PIX_W'($urandom) | PIX_W'(1);
                exp_q.push_back(ref_edge(x, y) ? 0 : int'(in_pix));
                tim_q.push_back(cyc);
                tag_q.push_back(tag);
            end
            for (int g = 0; g < int'($urandom % (gapmax + 1)); g++) begin
                @(negedge clk);
                in_vld = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
                in_top_word = $urandom; in_mid_word = $urandom; in_bot_word = $urandom;
            end
        end
        @(negedge clk);
        in_vld = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Output monitor: value, latency and idle checks.
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected output", int'(out_pix), -1);
                end else begin
                    int    e, t;
                    string tg;
                    e = exp_q.pop_front();
                    t = tim_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(int'(out_pix) == e, tg, "merged pixel", int'(out_pix), e);
                    chk(cyc - t == 2, "R2", "latency", cyc - t, 2);
                end
            end else begin
                chk(out_pix == '0, "R2", "idle output", int'(out_pix), 0);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(negedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0417));
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0 && out_pix == '0, "R1", "in reset", int'(out_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_vld == 1'b0 && out_pix == '0, "R1", "after reset", int'(out_pix), 0);
        mon_on = 1;
        // R3: flat images pass through.
        fill(1, 40, 3);  run_image("R3", 2);
        fill(2, 40, 5);  run_image("R3", 1);
        // R4: single dot, stripe and random content.
        fill(3, 9, 5);   run_image("R4", 1);
        fill(4, 12, 4);  run_image("R4", 2);
        fill(0, 70, 5);  run_image("R4", 2);
        fill(0, 33, 4);  run_image("R4", 1);
        // R5: multiword rows with random words between group starts.
        fill(0, 96, 4);  run_image("R5", 1);
        fill(0, 64, 6);  run_image("R5", 0);
        // R6: back-to-back rows, odd widths, ones at the borders.
        fill(2, 37, 4);  run_image("R6", 0);
        fill(0, 31, 6);  run_image("R6", 0);
        // R7: single and double row images, garbage outside.
        fill(2, 20, 1);  run_image("R7", 0);
        fill(2, 45, 2);  run_image("R7", 1);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "outputs missing", exp_q.size(), 0);
        finish_run();
    end

endmodule